// File: doc/BRIEF.md
# Logical Device Resource Register File

This block holds the resource configuration of one logical device that sits behind an indexed configuration port. A host selects a register by an 8-bit index and writes or reads one byte at a time. The block keeps the enable bit, the bus conflict-probe control, several memory window descriptors, a set of I/O port bases, interrupt entries and DMA channel selects. Fields that are reserved read back as zero, and the width-mode bit of each memory descriptor is fixed at build time.

While the conflict probe is switched on and the device is not enabled, the block answers I/O bus reads that land inside any of its programmed port windows. It returns one of two fixed byte patterns, so software can find overlapping assignments before it enables the device. Register reads and bus answers are both registered and appear one clock after their strobe.

Top module: `ldev_cfg_regs`

## Requirements
- R1: After reset every register reads 0x00, except the DMA selects at 0x74 and 0x75, which read 0x04 (no channel). reg_rdata and io_drive are 0.
- R2: The enable register at index 0x30 stores written bit 0. Bits [7:1] always read 0.
- R3: The probe control register at index 0x31 stores bit 1 (probe on) and bit 0 (pattern select). Bits [7:2] always read 0.
- R4: The port base of window i is at index 0x60+2i, high byte first (bits [15:8]), then low byte (bits [7:0]) at 0x61+2i. Both bytes read back in full.
- R5: Memory descriptor m occupies indices 0x40+8m to 0x44+8m: base bits [23:16], base bits [15:8], control, limit/length high, limit/length low. Byte registers read back in full. The control byte stores bit 1 (16-bit width). Its bit 0 always reads the MEM_LIMIT_BIT parameter and ignores writes. Bits [7:2] read 0.
- R6: Interrupt entry k has a level byte at 0x70+2k that stores bits [3:0], with upper bits reading 0. It has a type byte at 0x71+2k that stores bit 1 (polarity, 1 = high) and bit 0 (1 = level, 0 = edge), with upper bits reading 0.
- R7: DMA select j at 0x74+j stores bits [2:0]. Upper bits read 0.
- R8: Indices with no register, including offsets 5 to 7 of a memory descriptor, read 0x00. Writes to them change no register.
- R9: reg_rdata takes the value of the indexed register in the cycle after reg_rd is high. It holds its value while reg_rd is low.
- R10: When the probe is on and the device is not enabled, an io_rd at an address in [base, base+IO_SPAN) of a window with a nonzero base sets io_drive in the next cycle. io_rdata is then 0x55 if the pattern select bit is 1, and 0xAA if it is 0.
- R11: io_drive stays low, and io_rdata reads 0x00, when the device is enabled, when the probe is off, when the address lies outside every window, or when the only matching base is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Registered read data |
| io_addr | input | 16 | I/O bus address |
| io_rd | input | 1 | I/O bus read strobe |
| io_rdata | output | 8 | Probe response byte |
| io_drive | output | 1 | Probe response drive enable |

## Verification
The bench builds the block with IO_SPAN set to 4 and MEM_LIMIT_BIT set to 1. The short window makes both edges of a port range, the last address inside and the first outside, easy to hit with a few reads. The fixed control bit set to 1 exposes any write that wrongly reaches it: writing 0x00 to a control byte must still read back 0x01. The default counts for windows, descriptors, interrupts and DMA selects are kept, so the first and last instance of each register group can be checked.

// File: rtl/ldev_cfg_pkg.sv
package ldev_cfg_pkg;

    localparam logic [7:0] IDX_ENABLE   = 8'h30;
    localparam logic [7:0] IDX_PROBE    = 8'h31;
    localparam logic [7:0] IDX_MEM_BASE = 8'h40;
    localparam logic [7:0] IDX_IO_BASE  = 8'h60;
    localparam logic [7:0] IDX_IRQ_BASE = 8'h70;
    localparam logic [7:0] IDX_DMA_BASE = 8'h74;

    localparam int MEM_STRIDE = 8;
    localparam int IO_STRIDE  = 2;
    localparam int IRQ_STRIDE = 2;

    localparam logic [2:0] DMA_NONE  = 3'd4;
    localparam logic [7:0] PAT_ONE   = 8'h55;
    localparam logic [7:0] PAT_ZERO  = 8'hAA;

    typedef struct packed {
        logic [7:0] base_hi;
        logic [7:0] base_lo;
        logic       wide16;
        logic [7:0] lim_hi;
        logic [7:0] lim_lo;
    } mem_desc_t;

    typedef struct packed {
        logic [3:0] level;
        logic       pol_high;
        logic       trig_level;
    } irq_entry_t;

endpackage

// File: rtl/ldev_io_match.sv
module ldev_io_match #(
    parameter int NUM_IO  = 8,
    parameter int IO_SPAN = 8,
    parameter int AW      = 16
) (
    input  logic [AW-1:0]              addr,
    input  logic [NUM_IO-1:0][AW-1:0]  bases,
    output logic                       hit
);
    localparam logic [AW:0] SPAN_W = (AW+1)'(IO_SPAN);

    logic [NUM_IO-1:0] win_hit;

    for (genvar g = 0; g < NUM_IO; g++) begin : g_win
        logic [AW:0] lo_e;
        logic [AW:0] hi_e;
        assign lo_e = {1'b0, bases[g]};
        assign hi_e = lo_e + SPAN_W;
        assign win_hit[g] = (bases[g] != '0) &&
                            ({1'b0, addr} >= lo_e) &&
                            ({1'b0, addr} <  hi_e);
    end

    assign hit = |win_hit;

endmodule

// File: rtl/ldev_cfg_store.sv
module ldev_cfg_store
    import ldev_cfg_pkg::*;
#(
    parameter int NUM_IO        = 8,
    parameter int NUM_MEM       = 4,
    parameter int NUM_IRQ       = 2,
    parameter int NUM_DMA       = 2,
    parameter bit MEM_LIMIT_BIT = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 idx,
    input  logic [7:0]                 wdata,
    input  logic                       wr,
    output logic [7:0]                 rd_val,
    output logic                       enabled,
    output logic                       probe_on,
    output logic                       probe_sel,
    output logic [NUM_IO-1:0][15:0]    io_bases
);
    typedef struct packed {
        logic                              en;
        logic                              probe_on;
        logic                              probe_sel;
        logic [NUM_IO-1:0][15:0]           io_base;
        mem_desc_t [NUM_MEM-1:0]           mem;
        irq_entry_t [NUM_IRQ-1:0]          irq;
        logic [NUM_DMA-1:0][2:0]           dma;
    } cfg_t;

    function automatic cfg_t reset_image();
        cfg_t v;
        v = '0;
        for (int j = 0; j < NUM_DMA; j++) v.dma[j] = DMA_NONE;
        return v;
    endfunction

    localparam cfg_t CFG_RST = reset_image();

    cfg_t cfg_d, cfg_q;
    logic mapped;

    always_comb begin
        cfg_d  = cfg_q;
        rd_val = '0;
        mapped = 1'b0;

        if (idx == IDX_ENABLE) begin
            mapped = 1'b1;
            rd_val = {7'b0, cfg_q.en};
            if (wr) cfg_d.en = wdata[0];
        end
        if (idx == IDX_PROBE) begin
            mapped = 1'b1;
            rd_val = {6'b0, cfg_q.probe_on, cfg_q.probe_sel};
            if (wr) begin
                cfg_d.probe_on  = wdata[1];
                cfg_d.probe_sel = wdata[0];
            end
        end

        for (int m = 0; m < NUM_MEM; m++) begin
            logic [7:0] mb;
            mb = 8'(IDX_MEM_BASE + 8'(m * MEM_STRIDE));
            if (idx == mb) begin
                mapped = 1'b1;
                rd_val = cfg_q.mem[m].base_hi;
                if (wr) cfg_d.mem[m].base_hi = wdata;
            end
            if (idx == 8'(mb + 8'd1)) begin
                mapped = 1'b1;
                rd_val = cfg_q.mem[m].base_lo;
                if (wr) cfg_d.mem[m].base_lo = wdata;
            end
            if (idx == 8'(mb + 8'd2)) begin
                mapped = 1'b1;
                rd_val = {6'b0, cfg_q.mem[m].wide16, MEM_LIMIT_BIT};
                if (wr) cfg_d.mem[m].wide16 = wdata[1];
            end
            if (idx == 8'(mb + 8'd3)) begin
                mapped = 1'b1;
                rd_val = cfg_q.mem[m].lim_hi;
                if (wr) cfg_d.mem[m].lim_hi = wdata;
            end
            if (idx == 8'(mb + 8'd4)) begin
                mapped = 1'b1;
                rd_val = cfg_q.mem[m].lim_lo;
                if (wr) cfg_d.mem[m].lim_lo = wdata;
            end
        end

        for (int i = 0; i < NUM_IO; i++) begin
            logic [7:0] ib;
            ib = 8'(IDX_IO_BASE + 8'(i * IO_STRIDE));
            if (idx == ib) begin
                mapped = 1'b1;
                rd_val = cfg_q.io_base[i][15:8];
                if (wr) cfg_d.io_base[i][15:8] = wdata;
            end
            if (idx == 8'(ib + 8'd1)) begin
                mapped = 1'b1;
                rd_val = cfg_q.io_base[i][7:0];
                if (wr) cfg_d.io_base[i][7:0] = wdata;
            end
        end

        for (int k = 0; k < NUM_IRQ; k++) begin
            logic [7:0] qb;
            qb = 8'(IDX_IRQ_BASE + 8'(k * IRQ_STRIDE));
            if (idx == qb) begin
                mapped = 1'b1;
                rd_val = {4'b0, cfg_q.irq[k].level};
                if (wr) cfg_d.irq[k].level = wdata[3:0];
            end
            if (idx == 8'(qb + 8'd1)) begin
                mapped = 1'b1;
                rd_val = {6'b0, cfg_q.irq[k].pol_high, cfg_q.irq[k].trig_level};
                if (wr) begin
                    cfg_d.irq[k].pol_high   = wdata[1];
                    cfg_d.irq[k].trig_level = wdata[0];
                end
            end
        end

        for (int j = 0; j < NUM_DMA; j++) begin
            if (idx == 8'(IDX_DMA_BASE + 8'(j))) begin
                mapped = 1'b1;
                rd_val = {5'b0, cfg_q.dma[j]};
                if (wr) cfg_d.dma[j] = wdata[2:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign enabled   = cfg_q.en;
    assign probe_on  = cfg_q.probe_on;
    assign probe_sel = cfg_q.probe_sel;
    assign io_bases  = cfg_q.io_base;

    // R8: a write to an index with no register leaves the whole image unchanged
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mapped) |=> (cfg_q == $past(cfg_q)));

    // R7: a DMA select never reads back with bits [7:3] set
    a_r7_dma_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mapped && idx >= IDX_DMA_BASE && idx < 8'(IDX_DMA_BASE + 8'(NUM_DMA)))
        |-> (rd_val[7:3] == 5'b0));

endmodule

// File: rtl/ldev_cfg_regs.sv
module ldev_cfg_regs
    import ldev_cfg_pkg::*;
#(
    parameter int NUM_IO        = 8,
    parameter int NUM_MEM       = 4,
    parameter int NUM_IRQ       = 2,
    parameter int NUM_DMA       = 2,
    parameter int IO_SPAN       = 8,
    parameter bit MEM_LIMIT_BIT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_idx,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_wr,
    input  logic        reg_rd,
    output logic [7:0]  reg_rdata,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    output logic [7:0]  io_rdata,
    output logic        io_drive
);
    localparam int AW = 16;

    typedef struct packed {
        logic [7:0] rdata;
        logic       drive;
        logic [7:0] bus;
    } resp_t;

    logic [7:0]                 rd_val;
    logic                       enabled, probe_on, probe_sel, win_hit;
    logic [NUM_IO-1:0][AW-1:0]  io_bases;
    resp_t                      resp_d, resp_q;

    ldev_cfg_store #(
        .NUM_IO(NUM_IO), .NUM_MEM(NUM_MEM), .NUM_IRQ(NUM_IRQ),
        .NUM_DMA(NUM_DMA), .MEM_LIMIT_BIT(MEM_LIMIT_BIT)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .idx(reg_idx), .wdata(reg_wdata),
        .wr(reg_wr), .rd_val(rd_val), .enabled(enabled),
        .probe_on(probe_on), .probe_sel(probe_sel), .io_bases(io_bases)
    );

    ldev_io_match #(.NUM_IO(NUM_IO), .IO_SPAN(IO_SPAN), .AW(AW)) u_match (
        .addr(io_addr), .bases(io_bases), .hit(win_hit)
    );

    always_comb begin
        resp_d = resp_q;
        if (reg_rd) resp_d.rdata = rd_val;
        resp_d.drive = io_rd && win_hit && probe_on && !enabled;
        resp_d.bus   = resp_d.drive ? (probe_sel ? PAT_ONE : PAT_ZERO) : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign reg_rdata = resp_q.rdata;
    assign io_drive  = resp_q.drive;
    assign io_rdata  = resp_q.bus;

    // R10: the driven byte follows the pattern select of the previous cycle
    a_r10_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        io_drive |-> (io_rdata == ($past(probe_sel) ? PAT_ONE : PAT_ZERO)));

    // R11: an answer needs a bus read, an enabled probe and a disabled device
    a_r11_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        io_drive |-> ($past(io_rd) && $past(probe_on) && !$past(enabled)));

    // R11: no answer means a zero byte
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !io_drive |-> (io_rdata == 8'h00));

    // R9: read data holds without a read strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_rd) |-> $stable(reg_rdata));

endmodule

// File: tb/ldev_cfg_regs_test.sv
`timescale 1ns/1ps
module ldev_cfg_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_idx = '0, reg_wdata = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_drive;

    int n_cmp = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    ldev_cfg_regs #(.IO_SPAN(4), .MEM_LIMIT_BIT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .io_addr(io_addr), .io_rd(io_rd), .io_rdata(io_rdata), .io_drive(io_drive)
    );

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] wdata;
        logic [7:0] expv;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{8'h30, 8'hFF, 8'h01, 8'd2},   // R2
        '{8'h31, 8'hFF, 8'h03, 8'd3},   // R3
        '{8'h60, 8'h12, 8'h12, 8'd4},   // R4
        '{8'h61, 8'h34, 8'h34, 8'd4},   // R4
        '{8'h6E, 8'hAB, 8'hAB, 8'd4},   // R4
        '{8'h6F, 8'hCD, 8'hCD, 8'd4},   // R4
        '{8'h40, 8'hC0, 8'hC0, 8'd5},   // R5
        '{8'h41, 8'hDE, 8'hDE, 8'd5},   // R5
        '{8'h42, 8'hFF, 8'h03, 8'd5},   // R5
        '{8'h42, 8'h00, 8'h01, 8'd5},   // R5
        '{8'h43, 8'h77, 8'h77, 8'd5},   // R5
        '{8'h44, 8'h88, 8'h88, 8'd5},   // R5
        '{8'h5A, 8'h00, 8'h01, 8'd5},   // R5
        '{8'h70, 8'hFF, 8'h0F, 8'd6},   // R6
        '{8'h71, 8'hFF, 8'h03, 8'd6},   // R6
        '{8'h72, 8'h05, 8'h05, 8'd6},   // R6
        '{8'h74, 8'hFF, 8'h07, 8'd7},   // R7
        '{8'h75, 8'h02, 8'h02, 8'd7},   // R7
        '{8'h45, 8'hFF, 8'h00, 8'd8},   // R8
        '{8'h32, 8'hFF, 8'h00, 8'd8},   // R8
        '{8'h08, 8'hFF, 8'h00, 8'd8},   // R8
        '{8'h76, 8'hFF, 8'h00, 8'd8}    // R8
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
        @(negedge clk);
        reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] i);
        @(negedge clk);
        reg_idx = i; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", reg_rdata, 8'h00);
        check("R1", {7'b0, io_drive}, 8'h00);
        rd_reg(8'h30); check("R1", reg_rdata, 8'h00);
        rd_reg(8'h74); check("R1", reg_rdata, 8'h04);
        rd_reg(8'h75); check("R1", reg_rdata, 8'h04);
        rd_reg(8'h60); check("R1", reg_rdata, 8'h00);

        // R2..R8: write then read back each vector
        for (int v = 0; v < NV; v++) begin
            wr_reg(VECS[v].idx, VECS[v].wdata);
            rd_reg(VECS[v].idx);
            check($sformatf("R%0d idx %02h", VECS[v].req, VECS[v].idx),
                  reg_rdata, VECS[v].expv);
        end

        // R8: the unmapped writes above left neighbours intact
        rd_reg(8'h31); check("R8", reg_rdata, 8'h03);
        rd_reg(8'h30); check("R8", reg_rdata, 8'h01);
        rd_reg(8'h44); check("R8", reg_rdata, 8'h88);

        // R9: no strobe, new index, output holds
        @(negedge clk); reg_idx = 8'h40;
        @(negedge clk); @(negedge clk);
        check("R9", reg_rdata, 8'h88);

        // R11: device enabled, probe on: silent
        bus_rd(16'h1234);
        check("R11", {7'b0, io_drive}, 8'h00);
        check("R11", io_rdata, 8'h00);

        // R10: disable device, probe answers 0x55
        wr_reg(8'h30, 8'h00);
        bus_rd(16'h1234);
        check("R10", {7'b0, io_drive}, 8'h01);
        check("R10", io_rdata, 8'h55);
        bus_rd(16'h1237);
        check("R10", io_rdata, 8'h55);
        // R11: window edges
        bus_rd(16'h1238);
        check("R11", {7'b0, io_drive}, 8'h00);
        bus_rd(16'h1233);
        check("R11", {7'b0, io_drive}, 8'h00);
        // R11: no read strobe, address in range
        @(negedge clk); io_addr = 16'h1235;
        @(negedge clk);
        check("R11", {7'b0, io_drive}, 8'h00);

        // R10: pattern select clear answers 0xAA on last window
        wr_reg(8'h31, 8'h02);
        bus_rd(16'hABCF);
        check("R10", io_rdata, 8'hAA);

        // R11: probe off
        wr_reg(8'h31, 8'h00);
        bus_rd(16'h1234);
        check("R11", {7'b0, io_drive}, 8'h00);

        // R11: zero bases never match
        wr_reg(8'h31, 8'h03);
        bus_rd(16'h0000);
        check("R11", {7'b0, io_drive}, 8'h00);
        bus_rd(16'h0002);
        check("R11", {7'b0, io_drive}, 8'h00);

        // R1: reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_reg(8'h60); check("R1", reg_rdata, 8'h00);
        rd_reg(8'h75); check("R1", reg_rdata, 8'h04);
        rd_reg(8'h31); check("R1", reg_rdata, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule